// File: doc/BRIEF.md
# Verdict-Gated Packet Buffer

This block sits between a packet source and a packet sink. A separate classifier inspects each packet's header on its own path. Every incoming packet is stored whole and unmodified in a word FIFO. Meanwhile a set of filter flags comes back for each packet, one set per packet, in the order the packets arrived. The block reduces those flags to a single verdict and queues it.

The output side looks at the packet at the head of the buffer and holds it until the matching verdict is at the head of the verdict queue. A bypass verdict sends the packet out word for word, with its start and end markers, under normal valid/ready flow control. A drop verdict drains the packet at one word per cycle, and no word of it appears on the output. The verdict is consumed on the packet's last word.

Forwarding can start while the tail of a packet is still arriving, provided its verdict is already known. Both input queues apply backpressure through their ready signals, so no word or verdict is ever lost.

Top module: `pkt_verdict_buffer`

## Requirements
- R1: `in_ready_o` is low exactly when the packet buffer holds `PKT_DEPTH` words. A word is taken on a rising clock edge where `in_valid_i` and `in_ready_o` are both high, and no packet is truncated.
- R2: `vd_ready_o` is low exactly when the verdict queue holds `VQ_DEPTH` verdicts. A verdict is taken on an edge where `vd_valid_i` and `vd_ready_o` are both high.
- R3: A verdict means drop when at least one bit of `vd_flags_i` is 1, and bypass only when all bits are 0.
- R4: Verdicts pair with packets strictly in arrival order. Exactly one verdict is consumed per packet, on the cycle its end-marked word leaves the buffer.
- R5: A bypass packet appears on the output with every data word, `out_sop_o` (first word) and `out_eop_o` (last word) identical to the input and in the same order. The output packet sequence equals the input sequence with dropped packets deleted.
- R6: A drop packet produces no output word. It is removed from the buffer at one word per cycle while `out_valid_o` stays low, whatever the state of `out_ready_i`.
- R7: While the verdict queue is empty, `out_valid_o` stays low and the head packet stays in the buffer.
- R8: When `out_valid_o` is high and `out_ready_i` is low, the next cycle keeps `out_valid_o` high with `out_data_o`, `out_sop_o` and `out_eop_o` unchanged.
- R9: After reset, `out_valid_o` is low and both `in_ready_o` and `vd_ready_o` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word valid |
| in_data_i | input | DATA_W | Input word |
| in_sop_i | input | 1 | First word of a packet |
| in_eop_i | input | 1 | Last word of a packet |
| in_ready_o | output | 1 | Packet buffer can accept a word |
| vd_valid_i | input | 1 | Verdict flags valid |
| vd_flags_i | input | N_FILT | One flag per filter, 1 = flagged |
| vd_ready_o | output | 1 | Verdict queue can accept |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | DATA_W | Output word |
| out_sop_o | output | 1 | First word of a forwarded packet |
| out_eop_o | output | 1 | Last word of a forwarded packet |
| out_ready_i | input | 1 | Sink accepts the output word |

## Verification
The hardest case to reach from the ports is a dropped packet whose words are fully buffered when its verdict lands, directly ahead of a bypass packet. Only in that case does the silent one-word-per-cycle drain show up as a measurable gap before the next output word. The bench creates it by loading both packets with no verdicts present, checking that nothing leaves, and then posting drop and bypass verdicts back to back while it counts the idle output cycles. Full-queue conditions are reached by starving the buffer of verdicts for an over-long packet and by pre-loading verdicts with no packets present.

// File: rtl/pvb_pkg.sv
package pvb_pkg;
  typedef enum logic {
    VERD_PASS = 1'b0,
    VERD_DROP = 1'b1
  } verdict_e;
endpackage

// File: rtl/pvb_fifo.sv
// Show-ahead FIFO; DEPTH must be a power of two, at least 2.
module pvb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr_q, rd_ptr_q;

  assign empty_o = (wr_ptr_q == rd_ptr_q);
  assign full_o  = (wr_ptr_q[AW] != rd_ptr_q[AW]) &&
                   (wr_ptr_q[AW-1:0] == rd_ptr_q[AW-1:0]);
  assign rdata_o = mem[rd_ptr_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= rd_ptr_q + 1'b1;
    end
  end

  a_r1_r2_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r4_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/pvb_verdict_or.sv
// Any flagged filter turns the verdict into drop (R3).
module pvb_verdict_or #(
  parameter int N_FILT = 2
) (
  input  logic [N_FILT-1:0] flags_i,
  output pvb_pkg::verdict_e verdict_o
);
  assign verdict_o = (|flags_i) ? pvb_pkg::VERD_DROP : pvb_pkg::VERD_PASS;
endmodule

// File: rtl/pvb_release.sv
module pvb_release #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pk_empty_i,
  input  logic [DATA_W-1:0] pk_data_i,
  input  logic              pk_sop_i,
  input  logic              pk_eop_i,
  input  logic              vq_empty_i,
  input  pvb_pkg::verdict_e vq_verdict_i,
  input  logic              out_ready_i,
  output logic              pk_pop_o,
  output logic              vq_pop_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o
);
  logic head_ok, is_drop;

  assign head_ok     = !pk_empty_i && !vq_empty_i;
  assign is_drop     = (vq_verdict_i == pvb_pkg::VERD_DROP);
  assign out_valid_o = head_ok && !is_drop;
  // drop drains regardless of sink readiness
  assign pk_pop_o    = head_ok && (is_drop || out_ready_i);
  assign vq_pop_o    = pk_pop_o && pk_eop_i;
  assign out_data_o  = pk_data_i;
  assign out_sop_o   = pk_sop_i;
  assign out_eop_o   = pk_eop_i;

  a_r7_wait_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vq_empty_i |-> (!out_valid_o && !pk_pop_o));
  a_r6_drop_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vq_empty_i && vq_verdict_i == pvb_pkg::VERD_DROP) |-> !out_valid_o);
  a_r4_verdict_on_eop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vq_pop_o |-> (pk_pop_o && pk_eop_i));
  a_r8_stall_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) &&
                                       $stable(out_sop_o) && $stable(out_eop_o)));
endmodule

// File: rtl/pkt_verdict_buffer.sv
module pkt_verdict_buffer #(
  parameter int DATA_W    = 32,
  parameter int PKT_DEPTH = 64,
  parameter int VQ_DEPTH  = 8,
  parameter int N_FILT    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sop_i,
  input  logic              in_eop_i,
  output logic              in_ready_o,
  input  logic              vd_valid_i,
  input  logic [N_FILT-1:0] vd_flags_i,
  output logic              vd_ready_o,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sop_o,
  output logic              out_eop_o,
  input  logic              out_ready_i
);
  localparam int PW = DATA_W + 2;

  logic          pk_full, pk_empty, pk_push, pk_pop;
  logic [PW-1:0] pk_rdata;
  logic          vq_full, vq_empty, vq_push, vq_pop;
  logic [0:0]    vq_rdata;
  pvb_pkg::verdict_e vd_in, vq_head;

  assign in_ready_o = !pk_full;
  assign pk_push    = in_valid_i && !pk_full;
  assign vd_ready_o = !vq_full;
  assign vq_push    = vd_valid_i && !vq_full;
  assign vq_head    = pvb_pkg::verdict_e'(vq_rdata[0]);

  pvb_fifo #(.WIDTH(PW), .DEPTH(PKT_DEPTH)) u_pkt_fifo (
    .clk_i, .rst_ni,
    .push_i (pk_push),
    .wdata_i({in_sop_i, in_eop_i, in_data_i}),
    .pop_i  (pk_pop),
    .rdata_o(pk_rdata),
    .empty_o(pk_empty),
    .full_o (pk_full)
  );

  pvb_verdict_or #(.N_FILT(N_FILT)) u_vd_or (
    .flags_i  (vd_flags_i),
    .verdict_o(vd_in)
  );

  pvb_fifo #(.WIDTH(1), .DEPTH(VQ_DEPTH)) u_vq_fifo (
    .clk_i, .rst_ni,
    .push_i (vq_push),
    .wdata_i(vd_in),
    .pop_i  (vq_pop),
    .rdata_o(vq_rdata),
    .empty_o(vq_empty),
    .full_o (vq_full)
  );

  pvb_release #(.DATA_W(DATA_W)) u_release (
    .clk_i, .rst_ni,
    .pk_empty_i  (pk_empty),
    .pk_data_i   (pk_rdata[DATA_W-1:0]),
    .pk_sop_i    (pk_rdata[PW-1]),
    .pk_eop_i    (pk_rdata[PW-2]),
    .vq_empty_i  (vq_empty),
    .vq_verdict_i(vq_head),
    .out_ready_i,
    .pk_pop_o    (pk_pop),
    .vq_pop_o    (vq_pop),
    .out_valid_o,
    .out_data_o,
    .out_sop_o,
    .out_eop_o
  );

  a_r9_reset_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (in_ready_o && vd_ready_o && !out_valid_o));
endmodule

// File: tb/pkt_verdict_buffer_bench.sv
module pkt_verdict_buffer_bench;
  localparam int DW = 16;
  localparam int PD = 16;
  localparam int VD = 4;
  localparam int NF = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_ready;
  logic [DW-1:0] in_data = '0;
  logic vd_valid = 1'b0, vd_ready;
  logic [NF-1:0] vd_flags = '0;
  logic out_valid, out_sop, out_eop;
  logic [DW-1:0] out_data;
  logic out_ready = 1'b1;

  always #5 clk = ~clk;

  pkt_verdict_buffer #(.DATA_W(DW), .PKT_DEPTH(PD), .VQ_DEPTH(VD), .N_FILT(NF))
    u_pkt_verdict_buffer (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_sop_i(in_sop),
    .in_eop_i(in_eop), .in_ready_o(in_ready),
    .vd_valid_i(vd_valid), .vd_flags_i(vd_flags), .vd_ready_o(vd_ready),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_sop_o(out_sop),
    .out_eop_o(out_eop), .out_ready_i(out_ready)
  );

  int n_tests = 0, n_fail = 0, acc_words = 0;
  bit done = 0, mon_en = 0, rand_on = 0;
  logic [DW+1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic send_pkt(input int len, input int base, input bit drop);
    if (!drop)
      for (int i = 0; i < len; i++)
        exp_q.push_back({i == 0, i == len - 1, DW'(base + i)});
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_data = DW'(base + i);
      in_sop = (i == 0); in_eop = (i == len - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk);
      acc_words++;
      #1 in_valid = 1'b0;
    end
  endtask

  task automatic send_vd(input logic [NF-1:0] f);
    @(negedge clk);
    vd_valid = 1'b1; vd_flags = f;
    #1;
    while (!vd_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 vd_valid = 1'b0;
  endtask

  task automatic wait_drain();
    for (int k = 0; k < 2000 && exp_q.size() != 0; k++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5", "words still expected", exp_q.size(), 0);
  endtask

  // scoreboard monitor
  logic stall_prev = 1'b0;
  logic [DW+1:0] prev_w = '0;
  always begin
    @(negedge clk); #1;
    if (mon_en) begin
      if (stall_prev)
        chk(out_valid && {out_sop, out_eop, out_data} == prev_w, "R8",
            "held word", int'({out_valid, out_sop, out_eop, out_data}),
            int'({1'b1, prev_w}));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          chk(1'b0, "R6", "unexpected output word", int'(out_data), -1);
        else begin
          logic [DW+1:0] e;
          e = exp_q.pop_front();
          chk({out_sop, out_eop, out_data} == e, "R5", "output word",
              int'({out_sop, out_eop, out_data}), int'(e));
        end
      end
      stall_prev = out_valid && !out_ready;
      prev_w = {out_sop, out_eop, out_data};
    end
  end

  // random sink backpressure
  always begin
    @(negedge clk);
    if (rand_on) out_ready = ($urandom % 3) != 0;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int base_acc, cnt;
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && in_ready && vd_ready, "R9", "in reset",
        int'({out_valid, in_ready, vd_ready}), 3);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!out_valid && in_ready && vd_ready, "R9", "after reset",
        int'({out_valid, in_ready, vd_ready}), 3);
    mon_en = 1'b1;

    // R7: buffered packets with no verdict stay put
    send_pkt(5, 16'h100, 1'b1);
    send_pkt(2, 16'h200, 1'b0);
    repeat (5) begin
      @(negedge clk); #1;
      chk(!out_valid, "R7", "out_valid without verdict", out_valid, 0);
    end
    // R6: drop verdict drains 5 words silently, one per cycle
    send_vd(3'b010);
    send_vd(3'b000);
    cnt = 0;
    @(negedge clk); #1;
    while (!out_valid && cnt < 50) begin cnt++; @(negedge clk); #1; end
    chk(cnt == 4, "R6", "idle cycles during drop drain", cnt, 4);
    wait_drain();

    // R1: over-long packet with no verdict fills the buffer
    base_acc = acc_words;
    fork send_pkt(20, 16'h300, 1'b0); join_none
    repeat (24) @(negedge clk);
    #1;
    chk(acc_words - base_acc == PD, "R1", "words accepted when full",
        acc_words - base_acc, PD);
    chk(!in_ready, "R1", "in_ready when full", in_ready, 0);
    send_vd(3'b000);
    wait fork;
    wait_drain();
    chk(in_ready, "R1", "in_ready after drain", in_ready, 1);

    // R2 / R3 / R4: verdicts ahead of packets, queue full
    send_vd(3'b000);
    send_vd(3'b100);
    send_vd(3'b000);
    send_vd(3'b011);
    @(negedge clk); #1;
    chk(!vd_ready, "R2", "vd_ready when full", vd_ready, 0);
    fork
      send_vd(3'b111);
      begin
        send_pkt(3, 16'h400, 1'b0);
        send_pkt(2, 16'h500, 1'b1);
        send_pkt(4, 16'h600, 1'b0);
        send_pkt(1, 16'h700, 1'b1);
        send_pkt(2, 16'h800, 1'b1);
      end
    join
    wait_drain();
    chk(vd_ready, "R2", "vd_ready after drain", vd_ready, 1);

    // single-word bypass packet (R5)
    fork send_pkt(1, 16'h900, 1'b0); send_vd(3'b000); join
    wait_drain();

    // R3 R4 R8: random traffic with sink backpressure
    begin
      logic [NF-1:0] fl[40];
      int ln[40];
      for (int k = 0; k < 40; k++) begin
        fl[k] = ($urandom % 2) ? '0 : NF'($urandom);
        ln[k] = 1 + ($urandom % 6);
      end
      rand_on = 1'b1;
      fork
        for (int k = 0; k < 40; k++) begin
          send_pkt(ln[k], 16'h1000 + k * 16, |fl[k]);
          repeat ($urandom % 3) @(negedge clk);
        end
        for (int k = 0; k < 40; k++) begin
          send_vd(fl[k]);
          repeat ($urandom % 8) @(negedge clk);
        end
      join
      rand_on = 1'b0;
      @(negedge clk);
      out_ready = 1'b1;
    end
    wait_drain();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule